// File: doc/BRIEF.md
# Bit-Addressable Memory Bit Unit

The block carries out single-bit operations on a byte-wide data space, with a carry flag acting as a one-bit accumulator. An 8-bit bit address picks one bit either in a sixteen-byte window of low RAM or in one of the special registers whose byte address is a multiple of eight. A bit is read into carry, combined with carry by AND or OR (true or inverted), or changed in place: written from carry, set, cleared, complemented, or tested and cleared in one step. Carry itself can be set, cleared or complemented without any memory access.

Any change to an addressed bit is a read-modify-write of the byte that holds it, done over a byte-wide port with a one-cycle read latency. The carry is kept in an internal status byte at register address 0xD0 (carry is its bit 7). Bit addresses that fall in that byte act on the internal register rather than on the memory port, and the whole byte is always visible on an output. A strobe with an opcode and a bit address starts one operation. A busy flag covers the memory phase and a one-cycle done pulse marks completion.

Top module: `bitop_unit`

## Requirements
- R1: A bit address below 0x80 selects bit (addr & 7) of byte 0x20 + (addr >> 3); for example bit address 0x1A reads byte 0x23 and acts on its bit 2.
- R2: A bit address of 0x80 or above selects bit (addr & 7) of byte (addr & 0xF8); for example 0x9B acts on bit 3 of byte 0x98.
- R3: Opcodes 0 (carry := bit), 5 (carry &= bit), 6 (carry &= ~bit), 7 (carry |= bit) and 8 (carry |= ~bit) change only carry and never write memory.
- R4: Opcodes 1 (bit := carry), 2 (bit := 1), 3 (bit := 0) and 4 (bit := ~bit) write back the whole byte with only the target bit changed. Carry is unchanged, unless the target is carry itself.
- R5: Opcode 9 (test and clear) gives taken_o = 1 with done_o exactly when the addressed bit was 1, leaves that bit 0 and leaves carry unchanged; taken_o is 0 for every other opcode.
- R6: Opcodes 10 (carry := 1), 11 (carry := 0) and 12 (carry := ~carry) make no memory access and raise done_o in the cycle after the strobe edge, without busy_o.
- R7: For a memory opcode the read strobe is on in the cycle after the strobe edge. A read-only opcode raises done_o two edges after the strobe edge. A bit-changing opcode holds the write strobe one cycle later, on the same byte address, and raises done_o three edges after the strobe edge. busy_o is 1 from the read cycle until done_o.
- R8: Bit addresses 0xD0 to 0xD7 act on the internal status byte shown on psw_o, with no memory access and the same cycle counts as R7; bit 0xD7 is the carry.
- R9: A strobe while busy_o is 1 is ignored, and opcodes 13 to 15 change neither carry nor memory; they only pulse done_o one cycle after the strobe edge.
- R10: After reset carry_o, psw_o, busy_o, done_o, taken_o, mem_rd_o and mem_wr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe, sampled when idle |
| op_i | input | 4 | Operation code |
| baddr_i | input | 8 | Bit address |
| mem_addr_o | output | 8 | Byte address of the memory port |
| mem_rd_o | output | 1 | Read strobe; data returns the next cycle |
| mem_rdata_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Memory phase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Test-and-clear found the bit set, valid with done_o |
| carry_o | output | 1 | Carry flag |
| psw_o | output | 8 | Internal status byte |

## Verification
Random opcodes over random bit addresses, over memory filled with random bytes, are compared against a reference model. That shows whether the target bit, the byte written back and the carry all follow the operation, and whether neighbouring bits survive. The address mix is weighted toward the status byte so that its internal path and the carry bit 0xD7 are told apart from the memory path. The address seen on the read strobe checks both mapping regions, and the per-opcode cycle counts separate carry-only, read-only and read-modify-write timing. Directed cases cover the mapping examples, test-and-clear on a set and on a clear bit, undefined opcodes, and a strobe given while busy.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_EX, ST_WR} fsm_e;

  localparam logic [3:0] OP_LD_C   = 4'd0;
  localparam logic [3:0] OP_ST_C   = 4'd1;
  localparam logic [3:0] OP_SET_B  = 4'd2;
  localparam logic [3:0] OP_CLR_B  = 4'd3;
  localparam logic [3:0] OP_CPL_B  = 4'd4;
  localparam logic [3:0] OP_AND_B  = 4'd5;
  localparam logic [3:0] OP_AND_NB = 4'd6;
  localparam logic [3:0] OP_OR_B   = 4'd7;
  localparam logic [3:0] OP_OR_NB  = 4'd8;
  localparam logic [3:0] OP_TCLR   = 4'd9;
  localparam logic [3:0] OP_SET_C  = 4'd10;
  localparam logic [3:0] OP_CLR_C  = 4'd11;
  localparam logic [3:0] OP_CPL_C  = 4'd12;

  function automatic logic op_uses_mem(input logic [3:0] op);
    return op <= OP_TCLR;
  endfunction

  function automatic logic op_writes_bit(input logic [3:0] op);
    return (op >= OP_ST_C && op <= OP_CPL_B) || op == OP_TCLR;
  endfunction
endpackage

// File: rtl/bitop_addr_dec.sv
module bitop_addr_dec #(
  parameter int          ADDR_W      = 8,
  parameter int          IDX_W       = 3,
  parameter logic [7:0]  RAM_BASE    = 8'h20,
  parameter logic [7:0]  STATUS_ADDR = 8'hD0
) (
  input  logic [ADDR_W-1:0] baddr_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic              status_hit_o
);
  localparam int WIN_W = ADDR_W - 1 - IDX_W;

  logic [WIN_W-1:0] win_off;
  assign win_off = baddr_i[ADDR_W-2:IDX_W];

  always_comb begin
    if (baddr_i[ADDR_W-1])
      byte_addr_o = {baddr_i[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
    else
      byte_addr_o = ADDR_W'(RAM_BASE) + ADDR_W'(win_off);
  end

  assign bit_idx_o    = baddr_i[IDX_W-1:0];
  assign status_hit_o = (byte_addr_o == ADDR_W'(STATUS_ADDR));
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              carry_o,
  output logic              taken_o
);
  logic cur_bit, new_bit;
  assign cur_bit = byte_i[idx_i];

  always_comb begin
    carry_o = carry_i;
    new_bit = cur_bit;
    taken_o = 1'b0;
    case (op_i)
      OP_LD_C:   carry_o = cur_bit;
      OP_AND_B:  carry_o = carry_i & cur_bit;
      OP_AND_NB: carry_o = carry_i & ~cur_bit;
      OP_OR_B:   carry_o = carry_i | cur_bit;
      OP_OR_NB:  carry_o = carry_i | ~cur_bit;
      OP_ST_C:   new_bit = carry_i;
      OP_SET_B:  new_bit = 1'b1;
      OP_CLR_B:  new_bit = 1'b0;
      OP_CPL_B:  new_bit = ~cur_bit;
      OP_TCLR: begin
        new_bit = 1'b0;
        taken_o = cur_bit;
      end
      OP_SET_C:  carry_o = 1'b1;
      OP_CLR_C:  carry_o = 1'b0;
      OP_CPL_C:  carry_o = ~carry_i;
      default:   ;
    endcase
  end

  // per-bit merge: only the selected lane takes the new value
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign byte_o[g] = (idx_i == IDX_W'(g)) ? new_bit : byte_i[g];
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         ADDR_W      = 8,
  parameter int         CARRY_POS   = 7,
  parameter logic [7:0] RAM_BASE    = 8'h20,
  parameter logic [7:0] STATUS_ADDR = 8'hD0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] baddr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic              carry_o,
  output logic [DATA_W-1:0] psw_o
);
  localparam int IDX_W = $clog2(DATA_W);

  fsm_e              state_q;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q;
  logic              st_hit_q;
  logic [DATA_W-1:0] rd_q, wdata_q, psw_q;
  logic              done_q, taken_q, tk_q;

  logic [ADDR_W-1:0] dec_byte;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_st;

  bitop_addr_dec #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .RAM_BASE(RAM_BASE), .STATUS_ADDR(STATUS_ADDR)
  ) u_dec (
    .baddr_i(baddr_i), .byte_addr_o(dec_byte), .bit_idx_o(dec_idx), .status_hit_o(dec_st)
  );

  logic [3:0]        alu_op;
  logic [DATA_W-1:0] src_byte, alu_byte;
  logic              alu_carry, alu_taken;

  assign alu_op   = (state_q == ST_IDLE) ? op_i : op_q;
  assign src_byte = st_hit_q ? psw_q : mem_rdata_i;

  bitop_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_alu (
    .op_i(alu_op), .byte_i(src_byte), .idx_i(idx_q), .carry_i(psw_q[CARRY_POS]),
    .byte_o(alu_byte), .carry_o(alu_carry), .taken_o(alu_taken)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      byte_q   <= '0;
      idx_q    <= '0;
      st_hit_q <= 1'b0;
      rd_q     <= '0;
      wdata_q  <= '0;
      psw_q    <= '0;
      done_q   <= 1'b0;
      taken_q  <= 1'b0;
      tk_q     <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (op_uses_mem(op_i)) begin
            op_q     <= op_i;
            byte_q   <= dec_byte;
            idx_q    <= dec_idx;
            st_hit_q <= dec_st;
            state_q  <= ST_RD;
          end else begin
            // carry-only or undefined code: finish at once
            psw_q[CARRY_POS] <= alu_carry;
            done_q           <= 1'b1;
          end
        end
        ST_RD: state_q <= ST_EX;
        ST_EX: begin
          rd_q <= src_byte;
          if (op_writes_bit(op_q)) begin
            wdata_q <= alu_byte;
            tk_q    <= alu_taken;
            state_q <= ST_WR;
          end else begin
            psw_q[CARRY_POS] <= alu_carry;
            done_q           <= 1'b1;
            state_q          <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (st_hit_q) psw_q <= wdata_q;
          done_q  <= 1'b1;
          taken_q <= tk_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = byte_q;
  assign mem_rd_o    = (state_q == ST_RD) && !st_hit_q;
  assign mem_wr_o    = (state_q == ST_WR) && !st_hit_q;
  assign mem_wdata_o = wdata_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign taken_o     = taken_q;
  assign carry_o     = psw_q[CARRY_POS];
  assign psw_o       = psw_q;

  p_rd_wr_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_wr_follows_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o, 2) && (mem_addr_o == $past(mem_addr_o, 2)));

  p_one_bit_changed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($countones(mem_wdata_o ^ rd_q) <= 1));

  p_carry_moves_at_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(carry_o));

  p_taken_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> done_o);

  p_done_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_min_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
endmodule

// File: tb/bitop_unit_bench.sv
`timescale 1ns/1ps
module bitop_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] baddr_i = '0;
  logic [7:0] mem_addr_o, mem_wdata_o, psw_o;
  logic [7:0] mem_rdata_i = '0;
  logic       mem_rd_o, mem_wr_o, busy_o, done_o, taken_o, carry_o;

  bitop_unit u_bitop_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .baddr_i(baddr_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o),
    .taken_o(taken_o), .carry_o(carry_o), .psw_o(psw_o)
  );

  always #2 clk_i = ~clk_i;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_psw = '0;
  logic [7:0] last_rd_addr = '0;
  int rd_cnt = 0, wr_cnt = 0;
  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      mem_rdata_i  <= mem[mem_addr_o];
      last_rd_addr <= mem_addr_o;
      rd_cnt       <= rd_cnt + 1;
    end
    if (mem_wr_o) begin
      mem[mem_addr_o] <= mem_wdata_o;
      wr_cnt          <= wr_cnt + 1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog expired: got %0d cycles expected below 100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [7:0] a);
    if (!a[7]) return 8'h20 + {4'b0000, a[6:3]};
    return {a[7:3], 3'b000};
  endfunction

  function automatic string req_of(input logic [3:0] op, input bit st);
    if (op >= 13) return "R9";
    if (op >= 10) return "R6";
    if (st) return "R8";
    if (op == 9) return "R5";
    if (op >= 1 && op <= 4) return "R4";
    return "R3";
  endfunction

  task automatic check_mem(input string req);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < 256; i++)
      if (ok && mem[i] !== ref_mem[i]) begin ok = 0; bad = i; end
    chk(ok, req, $sformatf("memory byte %0h", bad), int'(mem[bad]), int'(ref_mem[bad]));
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input bit inject);
    logic [7:0] b, cur, nb;
    logic [2:0] ix;
    bit st, bv, c, nc, tk, rmw, mop;
    int exp_lat, n, rd0, wr0;
    string rq;
    b = ref_byte(a); ix = a[2:0];
    st = (b == 8'hD0);
    cur = st ? ref_psw : ref_mem[b];
    bv = cur[ix]; c = ref_psw[7]; nc = c; nb = cur; tk = 0;
    mop = (op <= 9);
    rmw = (op >= 1 && op <= 4) || op == 9;
    case (op)
      0: nc = bv;
      1: nb[ix] = c;
      2: nb[ix] = 1'b1;
      3: nb[ix] = 1'b0;
      4: nb[ix] = ~bv;
      5: nc = c & bv;
      6: nc = c & ~bv;
      7: nc = c | bv;
      8: nc = c | ~bv;
      9: begin tk = bv; nb[ix] = 1'b0; end
      10: nc = 1'b1;
      11: nc = 1'b0;
      12: nc = ~c;
      default: ;
    endcase
    if (rmw) begin
      if (st) ref_psw = nb; else ref_mem[b] = nb;
    end else ref_psw[7] = nc;
    exp_lat = !mop ? 0 : (rmw ? 3 : 2);
    rq = req_of(op, st);
    rd0 = rd_cnt; wr0 = wr_cnt;
    op_i = op; baddr_i = a; start_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 20) begin
      if (inject && n == 0) begin
        start_i = 1'b1; op_i = 4'd3; baddr_i = a ^ 8'h48;
      end
      @(posedge clk_i); @(negedge clk_i);
      start_i = 1'b0;
      n++;
    end
    chk(n == exp_lat, "R7", $sformatf("latency op %0d", op), n, exp_lat);
    chk(taken_o == tk, "R5", $sformatf("taken op %0d", op), int'(taken_o), int'(tk));
    chk(carry_o == ref_psw[7], rq, $sformatf("carry op %0d addr %0h", op, a), int'(carry_o), int'(ref_psw[7]));
    chk(psw_o == ref_psw, rq, "status byte", int'(psw_o), int'(ref_psw));
    chk(rd_cnt - rd0 == ((mop && !st) ? 1 : 0), inject ? "R9" : rq, "read count", rd_cnt - rd0, (mop && !st) ? 1 : 0);
    chk(wr_cnt - wr0 == ((rmw && !st) ? 1 : 0), rq, "write count", wr_cnt - wr0, (rmw && !st) ? 1 : 0);
    if (mop && !st)
      chk(last_rd_addr == b, a[7] ? "R2" : "R1", $sformatf("byte for bit %0h", a), int'(last_rd_addr), int'(b));
    check_mem(inject ? "R9" : rq);
  endtask

  initial begin
    logic [7:0] ra;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(carry_o == 1'b0, "R10", "carry", int'(carry_o), 0);
    chk(psw_o == 8'h00, "R10", "status byte", int'(psw_o), 0);
    chk(!busy_o && !done_o && !taken_o, "R10", "busy/done/taken", int'({busy_o, done_o, taken_o}), 0);
    chk(!mem_rd_o && !mem_wr_o, "R10", "memory strobes", int'({mem_rd_o, mem_wr_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 / R2 mapping examples
    run_op(4'd2, 8'h1A, 0);
    run_op(4'd4, 8'h9B, 0);
    run_op(4'd0, 8'h7F, 0);
    run_op(4'd3, 8'h80, 0);
    // R6 carry-only, R3 combining
    run_op(4'd10, 8'h00, 0);
    run_op(4'd1, 8'h05, 0);
    run_op(4'd11, 8'h00, 0);
    run_op(4'd8, 8'h05, 0);
    run_op(4'd12, 8'h00, 0);
    run_op(4'd6, 8'h05, 0);
    // R5 test-and-clear on set then cleared bit
    run_op(4'd2, 8'h33, 0);
    run_op(4'd9, 8'h33, 0);
    run_op(4'd9, 8'h33, 0);
    // R8 status byte path, carry at 0xD7
    run_op(4'd2, 8'hD7, 0);
    run_op(4'd4, 8'hD3, 0);
    run_op(4'd9, 8'hD7, 0);
    run_op(4'd7, 8'hD3, 0);
    // R9 undefined codes and strobe while busy
    run_op(4'd13, 8'h10, 0);
    run_op(4'd15, 8'hD7, 0);
    run_op(4'd2, 8'h05, 1);
    run_op(4'd4, 8'h9C, 1);

    for (int k = 0; k < 400; k++) begin
      ra = 8'($urandom);
      if ($urandom_range(0, 3) == 0) ra = {5'b11010, ra[2:0]};
      run_op(4'($urandom_range(0, 15)), ra, $urandom_range(0, 9) == 0);
    end
    summary();
  end
endmodule